// File: doc/BRIEF.md
# Hashed Indirect Branch Target Cache

This block predicts the destination of indirect branches. It keeps a set-associative table of (tag, target) pairs. The set is chosen by hashing three things: the branch address, a global history value and a short list of recently taken targets. All three arrive on the ports. The block keeps no path history of its own.

A front end presents a branch address with its history on the lookup side. In the same cycle it receives a hit flag and a predicted target. When the branch resolves, the same hash inputs arrive on the update side with the real target.

- If the indexed set already holds the tag, only the stored target is refreshed.
- Otherwise a way picked by a free-running pseudo-random sequence is overwritten with the new tag and target.

Top module: `itc_predictor`

## Requirements
- R1: After reset every entry is invalid and every lookup reports a miss with a target of zero.
- R2: The set index is the low log2(SETS) bits of a hash. The hash is the branch address shifted right by ALIGN, XORed with the history value when HASH_GHR is 1. SETS must be a power of two.
- R3: When HASH_PATH is 1, the path targets are packed youngest first (entry p in bits p*PC_W upward). Entry p, for p below the supplied count (the count never exceeding PATH_LEN), is shifted right by ALIGN + p*STEP and XORed into the hash, with STEP = floor(log2(SETS)) / PATH_LEN. Entries at or above the count have no effect.
- R4: The tag is the branch address shifted right by ALIGN, cut to TAG_W bits. A lookup hits only when a valid way of the indexed set holds that tag, and then returns that way's target; a miss returns zero.
- R5: An update whose tag is already present in the indexed set rewrites only that way's target. No other way changes and no entry is allocated.
- R6: An update that misses writes tag and target into way (S mod WAYS) of the indexed set and marks it valid. S is an 8-bit LFSR that is loaded with 0x01 in reset and, on every clock edge out of reset, becomes {S[6:0], S[7]^S[5]^S[4]^S[3]}. The victim uses the value S holds before that edge.
- R7: Lookup is combinational from the stored table. An update becomes visible at the next rising edge, so a lookup in the same cycle as an update sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Lookup branch address |
| lk_ghr | input | GHR_W | Lookup global history |
| lk_path | input | PATH_LEN*PC_W | Lookup recent targets, youngest in the low slot |
| lk_path_cnt | input | $clog2(PATH_LEN+1) | Number of valid lookup path entries |
| lk_hit | output | 1 | Lookup found a matching valid way |
| lk_target | output | PC_W | Predicted target, zero on miss |
| up_en | input | 1 | Update strobe |
| up_pc | input | PC_W | Resolved branch address |
| up_ghr | input | GHR_W | History used for the update index |
| up_path | input | PATH_LEN*PC_W | Recent targets used for the update index |
| up_path_cnt | input | $clog2(PATH_LEN+1) | Number of valid update path entries |
| up_target | input | PC_W | Resolved target |

## Verification
Directed patterns come first.

- Lookups with history only are told apart from lookups with history plus path entries.
- A path entry is shifted just far enough that its bits land above or below the index field. This separates a correct per-step shift from an off-by-one.
- Addresses differing only above the tag field must alias, while a different tag in the same set must miss.
- A same-cycle lookup and update separates registered from forwarded behaviour.

A long random mix over a small address pool then fills sets past their way count. This forces refreshes and pseudo-random evictions. Each of those is compared against a model stepping the same sequence.

// File: rtl/itc_predictor.sv
module itc_predictor #(
  parameter int SETS      = 8,
  parameter int WAYS      = 2,
  parameter int TAG_W     = 6,
  parameter int PC_W      = 16,
  parameter int GHR_W     = 8,
  parameter int PATH_LEN  = 2,
  parameter int ALIGN     = 2,
  parameter bit HASH_GHR  = 1'b1,
  parameter bit HASH_PATH = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PC_W-1:0]          lk_pc,
  input  logic [GHR_W-1:0]         lk_ghr,
  input  logic [PATH_LEN*PC_W-1:0] lk_path,
  input  logic [$clog2(PATH_LEN+1)-1:0] lk_path_cnt,
  output logic                     lk_hit,
  output logic [PC_W-1:0]          lk_target,
  input  logic                     up_en,
  input  logic [PC_W-1:0]          up_pc,
  input  logic [GHR_W-1:0]         up_ghr,
  input  logic [PATH_LEN*PC_W-1:0] up_path,
  input  logic [$clog2(PATH_LEN+1)-1:0] up_path_cnt,
  input  logic [PC_W-1:0]          up_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int STEP  = IDX_W / PATH_LEN;
  localparam int CNT_W = $clog2(PATH_LEN+1);
  localparam int ENT   = SETS * WAYS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [IDX_W-1:0] set_of(input logic [PC_W-1:0] pc,
      input logic [GHR_W-1:0] ghr, input logic [PATH_LEN*PC_W-1:0] path,
      input logic [CNT_W-1:0] cnt);
    logic [PC_W-1:0] h;
    h = pc >> ALIGN;
    if (HASH_GHR) h = h ^ PC_W'(ghr);
    if (HASH_PATH)
      for (int p = 0; p < PATH_LEN; p++)
        if (p < int'(cnt)) h = h ^ (path[p*PC_W +: PC_W] >> (ALIGN + p*STEP));
    return h[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] s;
    s = pc >> ALIGN;
    return s[TAG_W-1:0];
  endfunction

  logic [ENT-1:0]   vld;
  logic [TAG_W-1:0] tg  [ENT];
  logic [PC_W-1:0]  tgt [ENT];
  logic [7:0]       lfsr;

  wire [IDX_W-1:0] lk_set = set_of(lk_pc, lk_ghr, lk_path, lk_path_cnt);
  wire [IDX_W-1:0] up_set = set_of(up_pc, up_ghr, up_path, up_path_cnt);
  wire [TAG_W-1:0] lk_tag = tag_of(lk_pc);
  wire [TAG_W-1:0] up_tag = tag_of(up_pc);
  wire [WAY_W-1:0] victim = WAY_W'(lfsr % 8'(WAYS));

  logic [WAYS-1:0]  lk_match, up_match;
  logic [WAY_W-1:0] up_hit_way;
  int               wi;

  always_comb begin
    lk_target  = '0;
    up_hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      lk_match[w] = vld[int'(lk_set)*WAYS + w] && tg[int'(lk_set)*WAYS + w] == lk_tag;
      up_match[w] = vld[int'(up_set)*WAYS + w] && tg[int'(up_set)*WAYS + w] == up_tag;
      if (lk_match[w]) lk_target = tgt[int'(lk_set)*WAYS + w];
      if (up_match[w]) up_hit_way = WAY_W'(w);
    end
    wi = int'(up_set)*WAYS + int'(|up_match ? up_hit_way : victim);
  end

  assign lk_hit = |lk_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      lfsr <= 8'h01;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (up_en) begin
        tgt[wi] <= up_target;
        if (!(|up_match)) begin
          vld[wi] <= 1'b1;
          tg[wi]  <= up_tag;
        end
      end
    end
  end

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);
  p_one_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_refresh_keeps_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && (|up_match) |=> $countones(vld) == $countones($past(vld)));
  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 8'h00);
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> vld[$past(wi)] && tg[$past(wi)] == $past(up_tag)
              && tgt[$past(wi)] == $past(up_target));
endmodule

// File: tb/test_itc_predictor.sv
module test_itc_predictor;
  localparam int SETS = 8, WAYS = 2, TAG_W = 6, PC_W = 16, GHR_W = 8;
  localparam int PATH_LEN = 2, ALIGN = 2, STEP = 1, CNT_W = 2;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = 0, up_pc = 0, up_target = 0, lk_target;
  logic [GHR_W-1:0] lk_ghr = 0, up_ghr = 0;
  logic [PATH_LEN*PC_W-1:0] lk_path = 0, up_path = 0;
  logic [CNT_W-1:0] lk_path_cnt = 0, up_path_cnt = 0;
  logic up_en = 0, lk_hit;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  itc_predictor i_itc_predictor (.clk, .rst_n, .lk_pc, .lk_ghr, .lk_path, .lk_path_cnt,
    .lk_hit, .lk_target, .up_en, .up_pc, .up_ghr, .up_path, .up_path_cnt, .up_target);

  logic            m_vld [SETS*WAYS];
  logic [TAG_W-1:0] m_tag [SETS*WAYS];
  logic [PC_W-1:0]  m_tgt [SETS*WAYS];
  logic [7:0]       m_lfsr;

  function automatic int hidx(logic [PC_W-1:0] pc, logic [GHR_W-1:0] g,
                              logic [PATH_LEN*PC_W-1:0] pa, logic [CNT_W-1:0] c);
    int h;
    h = int'(pc) >> ALIGN;
    h = h ^ int'(g);
    for (int p = 0; p < int'(c); p++) h = h ^ (int'(pa[p*PC_W +: PC_W]) >> (ALIGN + p*STEP));
    return h % SETS;
  endfunction

  function automatic int htag(logic [PC_W-1:0] pc);
    return (int'(pc) >> ALIGN) % (1 << TAG_W);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr <= 8'h01;
      for (int e = 0; e < SETS*WAYS; e++) m_vld[e] <= 1'b0;
    end else begin
      m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
      if (up_en) begin
        automatic int s = hidx(up_pc, up_ghr, up_path, up_path_cnt);
        automatic int hw = -1;
        for (int w = 0; w < WAYS; w++)
          if (m_vld[s*WAYS+w] && int'(m_tag[s*WAYS+w]) == htag(up_pc)) hw = w;
        if (hw >= 0) m_tgt[s*WAYS+hw] <= up_target;
        else begin
          automatic int v = s*WAYS + int'(m_lfsr) % WAYS;
          m_vld[v] <= 1'b1;
          m_tag[v] <= TAG_W'(htag(up_pc));
          m_tgt[v] <= up_target;
        end
      end
    end
  end

  task automatic check(string r);
    automatic int s = hidx(lk_pc, lk_ghr, lk_path, lk_path_cnt);
    automatic logic eh = 1'b0;
    automatic logic [PC_W-1:0] et = '0;
    #1;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s*WAYS+w] && int'(m_tag[s*WAYS+w]) == htag(lk_pc)) begin
        eh = 1'b1; et = m_tgt[s*WAYS+w];
      end
    n_chk++;
    if (lk_hit !== eh || lk_target !== et) begin
      n_bad++;
      $display("FAIL %s pc=%h: hit=%b tgt=%h expected hit=%b tgt=%h", r, lk_pc, lk_hit, lk_target, eh, et);
    end
    @(negedge clk);
  endtask

  task automatic lk(logic [PC_W-1:0] pc, logic [GHR_W-1:0] g, logic [PATH_LEN*PC_W-1:0] pa, logic [CNT_W-1:0] c);
    lk_pc = pc; lk_ghr = g; lk_path = pa; lk_path_cnt = c; up_en = 0;
  endtask

  task automatic up(logic [PC_W-1:0] pc, logic [GHR_W-1:0] g, logic [PATH_LEN*PC_W-1:0] pa,
                    logic [CNT_W-1:0] c, logic [PC_W-1:0] t);
    up_en = 1; up_pc = pc; up_ghr = g; up_path = pa; up_path_cnt = c; up_target = t;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin lk(16'(i * 36), 8'(i), 32'h1234_5678, 2'(i % 3)); check("R1"); end
    lk(16'h0040, 0, 0, 0); up(16'h0040, 0, 0, 0, 16'h1234); check("R7 same-cycle old contents");
    lk(16'h0040, 0, 0, 0); check("R7 visible next cycle");
    up(16'h0040, 0, 0, 0, 16'h5678); check("R5 refresh");
    lk(16'h0040, 0, 0, 0); check("R5 refreshed target");
    lk(16'h0040, 8'h01, 0, 0); check("R2 ghr moves index");
    up(16'h0040, 8'h01, 0, 0, 16'h9999); check("R2 update other set");
    lk(16'h0040, 8'h01, 0, 0); check("R2 ghr set");
    lk(16'h0040, 8'h00, 0, 0); check("R2 base set");
    lk(16'h0040, 0, 32'hFFFF_FFFF, 0); check("R3 unused entries ignored");
    lk(16'h0040, 0, 32'h0000_0004, 1); check("R3 youngest shifts into index");
    lk(16'h0040, 0, 32'h0000_0020, 1); check("R3 youngest above index");
    lk(16'h0040, 0, 32'h0008_0020, 2); check("R3 older step shift changes index");
    lk(16'h0040, 0, 32'h0004_0020, 2); check("R3 older step shift drops bit");
    lk(16'h1040, 0, 0, 0); check("R4 alias above tag hits");
    lk(16'h0060, 0, 0, 0); check("R4 other tag misses");
    for (int i = 0; i < 6; i++) begin up(16'(i * 32), 0, 0, 0, 16'(16'hA000 + i)); check("R6 fill set"); end
    for (int i = 0; i < 6; i++) begin lk(16'(i * 32), 0, 0, 0); check("R6 victim choice"); end
    for (int i = 0; i < 4000; i++) begin
      automatic logic [PC_W-1:0] pc = 16'((($urandom % 24) << 2) | (($urandom % 2) << 12));
      automatic logic [PATH_LEN*PC_W-1:0] pa = {16'($urandom % 64), 16'($urandom % 64)};
      lk(pc, 8'($urandom % 4), pa, 2'($urandom % 3));
      if ($urandom % 2 == 1) up(16'((($urandom % 24) << 2)), 8'($urandom % 4), pa,
                                2'($urandom % 3), 16'($urandom));
      check("R6 random mix");
    end
    finish_run();
  end
endmodule